// File: doc/BRIEF.md
# Interrupt Redirection Router

This block takes interrupt request lines from a set of external pins and turns them into interrupt messages for processor-local interrupt controllers. Each pin owns one 64-bit routing entry. Software reads and writes the entry as two 32-bit words through a plain register port. The entry sets the vector, the target, how the target is addressed, the delivery kind, the input polarity, edge or level sensing, and a mask.

The block samples the pins and corrects them for polarity. Edge entries latch each inactive-to-active change. Level entries request for as long as the line stays active, but only while their remote-IRR flag is clear. Among the pins that are requesting, the lowest index wins. The winner is placed in a single output register and offered on a valid/ready interface.

After a processor takes a level interrupt, an accept strobe naming the pin sets that entry's remote-IRR flag. An end-of-interrupt strobe carrying a vector clears the flag in every level entry with that vector. A line that is still active then raises a fresh message.

Top module: `irq_redir_router`

## Requirements
- R1: After reset every entry reads with its mask bit (bit 16 of the low word) set and every other bit zero: the low word is 0x0001_0000, the high word 0, and no message is offered.
- R2: Register address = pin*2 + half. The low word (half 0) has these fields: vector 7:0, delivery mode 10:8, destination mode 11 (1 logical), delivery status 12, polarity 13 (1 active high), remote-IRR 14, trigger 15 (1 edge), mask 16. The high word (half 1) holds the destination in 31:24 and the extended destination in 23:16. All other bits read as zero.
- R3: Software writes to the delivery-status and remote-IRR bits have no effect.
- R4: An edge entry sends exactly one message for each inactive-to-active change of its polarity-corrected input. Returning to inactive sends nothing.
- R5: A masked entry never has a message loaded. An edge seen while masked stays latched, reads with status 1, and is sent once the mask is cleared.
- R6: A level entry requests while its corrected input is active and remote-IRR is clear. After its message handshake, it sends no further message until an end-of-interrupt clears it.
- R7: An accept strobe for a level entry sets its remote-IRR bit. For an edge entry, remote-IRR is never set.
- R8: An end-of-interrupt clears remote-IRR in every level entry whose vector equals the strobe's vector, and leaves other vectors untouched. A line still active afterwards sends a new message.
- R9: When several entries request at once, they are sent in order of increasing pin index.
- R10: A message carries its pin index and the entry's vector, destination, destination mode and delivery mode, plus a trigger flag that is 1 for edge and 0 for level.
- R11: While the message output is valid and not ready, the message stays valid and unchanged.
- R12: Delivery status reads 1 while the entry has a request waiting and returns to 0 once the message handshake completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_PINS | External interrupt lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | IDX_W+1 | Word address: pin index and half select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message taken |
| msg_pin | output | IDX_W | Source pin of the message |
| msg_vector | output | 8 | Interrupt vector |
| msg_dest | output | 8 | Destination |
| msg_dest_logical | output | 1 | 1 logical, 0 physical destination |
| msg_dlv_mode | output | 3 | Delivery mode code |
| msg_edge | output | 1 | 1 edge, 0 level triggered |
| acc_strobe | input | 1 | A processor accepted a message |
| acc_pin | input | IDX_W | Pin whose message was accepted |
| eoi_strobe | input | 1 | End-of-interrupt |
| eoi_vector | input | 8 | Vector of the end-of-interrupt |

## Verification
The bench first reads every entry after reset. It then checks the register layout with all-ones writes, and checks that writes to the flag bits are dropped. Next, all pins raise an edge together, with a distinct configuration per pin. This separates priority order, per-field routing and hold-under-backpressure in a single pass. A masked edge pulse distinguishes a dropped request from a latched one. An active-low level line is taken through handshake, accept, a non-matching and a matching end-of-interrupt, showing both the gating and the re-send. Two level pins that share a vector show that one end-of-interrupt releases both.

// File: rtl/irr_pkg.sv
`timescale 1ns/1ps
package irr_pkg;
  localparam int VEC_W = 8;

  typedef struct packed {
    logic [7:0]       dest;
    logic [7:0]       ext;
    logic             mask;
    logic             trig_edge;
    logic             pol_high;
    logic             dmode;
    logic [2:0]       dlv;
    logic [VEC_W-1:0] vec;
  } irr_cfg_t;

  localparam irr_cfg_t CFG_RST = '{mask: 1'b1, default: '0};
endpackage

// File: rtl/irr_entry.sv
`timescale 1ns/1ps
module irr_entry
  import irr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [31:0]      wdata,
  input  logic             pin_now,
  input  logic             pin_old,
  input  logic             take,
  input  logic             acc,
  input  logic             eoi,
  input  logic [VEC_W-1:0] eoi_vec,
  output irr_cfg_t         cfg,
  output logic             rirr,
  output logic             status,
  output logic             req
);
  irr_cfg_t cfg_q, cfg_d;
  logic edge_q, edge_d, rirr_q, rirr_d, wait_q, wait_d;
  logic act_now, act_old, lvl_ok, eoi_hit, cfg_en;

  assign cfg_en  = wr_lo | wr_hi;
  assign act_now = ~(pin_now ^ cfg_q.pol_high);
  assign act_old = ~(pin_old ^ cfg_q.pol_high);
  assign eoi_hit = eoi & (eoi_vec == cfg_q.vec) & ~cfg_q.trig_edge;
  assign lvl_ok  = ~cfg_q.trig_edge & act_now & ~rirr_q & ~wait_q;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_lo) begin
      cfg_d.vec       = wdata[7:0];
      cfg_d.dlv       = wdata[10:8];
      cfg_d.dmode     = wdata[11];
      cfg_d.pol_high  = wdata[13];
      cfg_d.trig_edge = wdata[15];
      cfg_d.mask      = wdata[16];
    end
    if (wr_hi) begin
      cfg_d.dest = wdata[31:24];
      cfg_d.ext  = wdata[23:16];
    end
    edge_d = cfg_q.trig_edge & ((act_now & ~act_old) | (edge_q & ~take));
    rirr_d = ~cfg_d.trig_edge & (acc | (rirr_q & ~eoi_hit));
    wait_d = ~cfg_d.trig_edge &
             ((take & ~cfg_q.trig_edge) | (wait_q & ~acc & ~eoi_hit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      edge_q <= 1'b0;
      rirr_q <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      if (cfg_en) cfg_q <= cfg_d;
      edge_q <= edge_d;
      rirr_q <= rirr_d;
      wait_q <= wait_d;
    end
  end

  assign cfg    = cfg_q;
  assign rirr   = rirr_q;
  assign req    = ~cfg_q.mask & (cfg_q.trig_edge ? edge_q : lvl_ok);
  assign status = cfg_q.trig_edge ? edge_q : (lvl_ok & ~cfg_q.mask);
endmodule

// File: rtl/irr_pick.sv
`timescale 1ns/1ps
module irr_pick #(
  parameter int N     = 24,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/irq_redir_router.sv
`timescale 1ns/1ps
module irq_redir_router
  import irr_pkg::*;
#(
  parameter  int NUM_PINS = 24,
  localparam int IDX_W    = $clog2(NUM_PINS),
  localparam int ADDR_W   = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [IDX_W-1:0]    msg_pin,
  output logic [VEC_W-1:0]    msg_vector,
  output logic [7:0]          msg_dest,
  output logic                msg_dest_logical,
  output logic [2:0]          msg_dlv_mode,
  output logic                msg_edge,
  input  logic                acc_strobe,
  input  logic [IDX_W-1:0]    acc_pin,
  input  logic                eoi_strobe,
  input  logic [VEC_W-1:0]    eoi_vector
);
  logic [NUM_PINS-1:0] pin_s, pin_p;
  logic [NUM_PINS-1:0] req_v, stat_v, rirr_v, mask_v, trig_v, take_v, acc_v;
  logic [NUM_PINS-1:0] wr_lo_v, wr_hi_v;
  irr_cfg_t            cfg_a [NUM_PINS];
  logic [IDX_W-1:0]    sel, pick_idx;
  logic                half, sel_ok, pick_any, hs, load, valid_d;
  irr_cfg_t            rd_cfg, win_cfg;

  assign sel    = reg_addr[ADDR_W-1:1];
  assign half   = reg_addr[0];
  assign sel_ok = (32'(sel) < NUM_PINS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s <= '0;
      pin_p <= '0;
    end else begin
      pin_s <= irq_in;
      pin_p <= pin_s;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
    assign wr_lo_v[i] = reg_we & sel_ok & (sel == IDX_W'(i)) & ~half;
    assign wr_hi_v[i] = reg_we & sel_ok & (sel == IDX_W'(i)) & half;
    assign take_v[i]  = hs & (msg_pin == IDX_W'(i));
    assign acc_v[i]   = acc_strobe & (acc_pin == IDX_W'(i));
    assign mask_v[i]  = cfg_a[i].mask;
    assign trig_v[i]  = cfg_a[i].trig_edge;
    irr_entry u_ent (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo   (wr_lo_v[i]),
      .wr_hi   (wr_hi_v[i]),
      .wdata   (reg_wdata),
      .pin_now (pin_s[i]),
      .pin_old (pin_p[i]),
      .take    (take_v[i]),
      .acc     (acc_v[i]),
      .eoi     (eoi_strobe),
      .eoi_vec (eoi_vector),
      .cfg     (cfg_a[i]),
      .rirr    (rirr_v[i]),
      .status  (stat_v[i]),
      .req     (req_v[i])
    );
  end

  irr_pick #(.N(NUM_PINS), .IDX_W(IDX_W)) u_pick (
    .req (req_v),
    .any (pick_any),
    .idx (pick_idx)
  );

  always_comb begin
    rd_cfg    = sel_ok ? cfg_a[sel] : CFG_RST;
    reg_rdata = '0;
    if (sel_ok) begin
      if (half) begin
        reg_rdata[31:24] = rd_cfg.dest;
        reg_rdata[23:16] = rd_cfg.ext;
      end else begin
        reg_rdata[7:0]  = rd_cfg.vec;
        reg_rdata[10:8] = rd_cfg.dlv;
        reg_rdata[11]   = rd_cfg.dmode;
        reg_rdata[12]   = stat_v[sel];
        reg_rdata[13]   = rd_cfg.pol_high;
        reg_rdata[14]   = rirr_v[sel];
        reg_rdata[15]   = rd_cfg.trig_edge;
        reg_rdata[16]   = rd_cfg.mask;
      end
    end
  end

  assign hs      = msg_valid & msg_ready;
  assign load    = ~msg_valid & pick_any;
  assign valid_d = load | (msg_valid & ~hs);
  assign win_cfg = cfg_a[pick_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid        <= 1'b0;
      msg_pin          <= '0;
      msg_vector       <= '0;
      msg_dest         <= '0;
      msg_dest_logical <= 1'b0;
      msg_dlv_mode     <= '0;
      msg_edge         <= 1'b0;
    end else begin
      msg_valid <= valid_d;
      if (load) begin
        msg_pin          <= pick_idx;
        msg_vector       <= win_cfg.vec;
        msg_dest         <= win_cfg.dest;
        msg_dest_logical <= win_cfg.dmode;
        msg_dlv_mode     <= win_cfg.dlv;
        msg_edge         <= win_cfg.trig_edge;
      end
    end
  end
endmodule

// File: rtl/irr_router_chk.sv
`timescale 1ns/1ps
module irr_router_chk #(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [IDX_W-1:0]    msg_pin,
  input logic [7:0]          msg_vector,
  input logic                acc_strobe,
  input logic [IDX_W-1:0]    acc_pin,
  input logic                reg_we,
  input logic [NUM_PINS-1:0] req_v,
  input logic [NUM_PINS-1:0] mask_v,
  input logic [NUM_PINS-1:0] trig_v,
  input logic [NUM_PINS-1:0] rirr_v
);
  logic [NUM_PINS-1:0] req_d, mask_d, below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d  <= '0;
      mask_d <= '1;
    end else begin
      req_d  <= req_v;
      mask_d <= mask_v;
    end
  end

  assign below = ({{(NUM_PINS-1){1'b0}}, 1'b1} << msg_pin) - {{(NUM_PINS-1){1'b0}}, 1'b1};

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_pin) && $stable(msg_vector)); // R11
  AST_NO_MASKED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> !mask_d[msg_pin]); // R5
  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> (req_d & below) == '0); // R9
  AST_RIRR_LEVEL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (rirr_v & trig_v) == '0); // R7
  AST_ACCEPT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_strobe && !reg_we && (32'(acc_pin) < NUM_PINS) && !trig_v[acc_pin]
    |=> rirr_v[$past(acc_pin)]); // R7
  AST_PIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> 32'(msg_pin) < NUM_PINS); // R10
endmodule

bind irq_redir_router irr_router_chk #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_pin    (msg_pin),
  .msg_vector (msg_vector),
  .acc_strobe (acc_strobe),
  .acc_pin    (acc_pin),
  .reg_we     (reg_we),
  .req_v      (req_v),
  .mask_v     (mask_v),
  .trig_v     (trig_v),
  .rirr_v     (rirr_v)
);

// File: tb/irq_redir_router_test.sv
`timescale 1ns/1ps
module irq_redir_router_test;
  localparam int NP = 24;
  localparam int IW = 5;

  logic clk, rst_n, reg_we, msg_ready, acc_strobe, eoi_strobe;
  logic [NP-1:0] irq_in;
  logic [IW:0]   reg_addr;
  logic [31:0]   reg_wdata, reg_rdata;
  logic          msg_valid, msg_dest_logical, msg_edge;
  logic [IW-1:0] msg_pin, acc_pin;
  logic [7:0]    msg_vector, msg_dest, eoi_vector;
  logic [2:0]    msg_dlv_mode;
  int checks = 0;
  int fails  = 0;

  irq_redir_router #(.NUM_PINS(NP)) uut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int pin, input int hf, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = (IW+1)'(pin * 2 + hf); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int pin, input int hf, output logic [31:0] d);
    @(negedge clk);
    reg_addr = (IW+1)'(pin * 2 + hf);
    #1 d = reg_rdata;
  endtask

  task automatic wait_msg(output bit got);
    got = 1'b0;
    for (int k = 0; k < 30 && !got; k++) begin
      @(negedge clk);
      if (msg_valid) got = 1'b1;
    end
  endtask

  task automatic take();
    @(negedge clk); msg_ready = 1'b1;
    @(negedge clk); msg_ready = 1'b0;
  endtask

  task automatic accept(input int pin);
    @(negedge clk); acc_strobe = 1'b1; acc_pin = IW'(pin);
    @(negedge clk); acc_strobe = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk); eoi_strobe = 1'b1; eoi_vector = v;
    @(negedge clk); eoi_strobe = 1'b0;
  endtask

  task automatic quiet(input string tag, input int n);
    bit seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    check(tag, 32'(seen), 32'd0);
  endtask

  function automatic logic [31:0] lo_val(input int i);
    return (32'h20 + i) | (32'(i % 8) << 8) | (32'(i & 1) << 11) | 32'h2000 | 32'h8000;
  endfunction

  initial begin
    logic [31:0] d;
    bit got;
    rst_n = 1'b0; irq_in = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    msg_ready = 1'b0; acc_strobe = 1'b0; acc_pin = '0; eoi_strobe = 1'b0; eoi_vector = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents of every entry
    for (int p = 0; p < NP; p++) begin
      rd(p, 0, d); check("R1 low word", d, 32'h0001_0000);
      rd(p, 1, d); check("R1 high word", d, 32'h0);
    end
    check("R1 no message", 32'(msg_valid), 32'd0);

    // R2: field layout with all-ones writes
    wr(0, 0, 32'hFFFF_FFFF);
    rd(0, 0, d); check("R2 low layout", d, 32'h0001_AFFF);
    wr(0, 1, 32'hFFFF_FFFF);
    rd(0, 1, d); check("R2 high layout", d, 32'hFFFF_0000);
    // R3: flag bits not writable
    wr(1, 0, 32'h0001_5000);
    rd(1, 0, d); check("R3 flags ignored", d, 32'h0001_0000);

    // R4 R9 R10 R11 R12: all pins edge, one burst
    for (int i = 0; i < NP; i++) begin
      wr(i, 1, 32'(i + 8'h40) << 24);
      wr(i, 0, lo_val(i));
    end
    @(negedge clk); irq_in = '1;
    repeat (2) @(negedge clk); irq_in = '0;
    repeat (3) @(negedge clk);
    rd(NP - 1, 0, d); check("R12 status pending", d, lo_val(NP - 1) | 32'h1000);
    for (int i = 0; i < NP; i++) begin
      wait_msg(got);
      check("R4 message present", 32'(got), 32'd1);
      check("R9 pin order", 32'(msg_pin), 32'(i));
      check("R10 vector", 32'(msg_vector), 32'h20 + i);
      check("R10 dest", 32'(msg_dest), 32'(i + 8'h40));
      check("R10 delivery mode", 32'(msg_dlv_mode), 32'(i % 8));
      check("R10 dest mode", 32'(msg_dest_logical), 32'(i & 1));
      check("R10 edge flag", 32'(msg_edge), 32'd1);
      if (i < 4) begin
        repeat (3) @(negedge clk);
        check("R11 held valid", 32'(msg_valid), 32'd1);
        check("R11 held pin", 32'(msg_pin), 32'(i));
      end
      take();
    end
    quiet("R4 no extra message", 12);
    rd(NP - 1, 0, d); check("R12 status idle", d, lo_val(NP - 1));

    // R5: edge while masked is kept
    wr(5, 0, lo_val(5) | 32'h1_0000);
    @(negedge clk); irq_in[5] = 1'b1;
    repeat (2) @(negedge clk); irq_in[5] = 1'b0;
    quiet("R5 masked silent", 10);
    rd(5, 0, d); check("R5 latched status", d, lo_val(5) | 32'h1_1000);
    wr(5, 0, lo_val(5));
    wait_msg(got);
    check("R5 sent after unmask", 32'(got), 32'd1);
    check("R5 pin", 32'(msg_pin), 32'd5);
    take();
    rd(5, 0, d); check("R12 status after take", d, lo_val(5));

    // R6 R7 R8: active-low level pin 7, vector 0x77
    wr(7, 0, 32'h0000_0077);
    wait_msg(got);
    check("R6 level message", 32'(got), 32'd1);
    check("R6 pin", 32'(msg_pin), 32'd7);
    check("R10 level flag", 32'(msg_edge), 32'd0);
    take();
    quiet("R6 no repeat before accept", 10);
    accept(7);
    rd(7, 0, d); check("R7 remote-IRR set", d, 32'h0000_4077);
    eoi(8'h78);
    rd(7, 0, d); check("R8 other vector no effect", d, 32'h0000_4077);
    quiet("R6 gated", 8);
    eoi(8'h77);
    wait_msg(got);
    check("R8 resend while active", 32'(got), 32'd1);
    check("R8 resend pin", 32'(msg_pin), 32'd7);
    take();
    accept(7);
    @(negedge clk); irq_in[7] = 1'b1;
    repeat (3) @(negedge clk);
    eoi(8'h77);
    quiet("R8 inactive no resend", 10);
    rd(7, 0, d); check("R8 remote-IRR cleared", d, 32'h0000_0077);

    // R7: edge entry ignores accept
    accept(0);
    rd(0, 0, d); check("R7 edge no remote-IRR", d, lo_val(0));

    // R8 R9: two level pins sharing vector 0x99, active high
    wr(9, 0, 32'h0000_2099);
    wr(10, 0, 32'h0000_2099);
    @(negedge clk); irq_in[9] = 1'b1; irq_in[10] = 1'b1;
    wait_msg(got); check("R9 first of pair", 32'(msg_pin), 32'd9);
    take();
    wait_msg(got); check("R9 second of pair", 32'(msg_pin), 32'd10);
    take();
    accept(9); accept(10);
    rd(9, 0, d);  check("R7 pin9 set", d, 32'h0000_6099);
    rd(10, 0, d); check("R7 pin10 set", d, 32'h0000_6099);
    @(negedge clk); irq_in[9] = 1'b0; irq_in[10] = 1'b0;
    repeat (3) @(negedge clk);
    eoi(8'h99);
    rd(9, 0, d);  check("R8 pin9 cleared", d, 32'h0000_2099);
    rd(10, 0, d); check("R8 pin10 cleared", d, 32'h0000_2099);
    quiet("R8 pair quiet", 10);

    report();
  end
endmodule